// File: doc/BRIEF.md
# Receive/Transmit FIFO Ready Signalling for a Serial Channel

This block holds the receive and transmit byte queues of one serial channel and drives two active-low service request outputs, `rxrdy_n` and `txrdy_n`. A host or a DMA controller watches these outputs to decide when to drain received bytes or refill transmit bytes. The serial shifter side and the host side talk to the queues through single-cycle push and pop strobes. The current fill level of each queue is visible on a count port.

Three control inputs choose how the ready outputs behave: a queue enable, a block-transfer (DMA) mode select, and a 2-bit receive threshold. With the queues off, each side acts as a single holding register. With the queues on and block mode off, the outputs report "any data" on the receive side and "completely empty" on the transmit side. With block mode on, the transmit output requests service while any slot is free. The receive output becomes a latched request that is set by the threshold or by a timeout, and it is released only when the receive queue runs dry.

Top module: `uart_fifo_ready`

## Requirements
- R1: After reset both counts are 0, `rxrdy_n` is 1, `txrdy_n` is 0 and both overrun outputs are 0.
- R2: With `fifo_en`=0 each side holds at most one byte. `rxrdy_n` is 0 exactly when `rx_count` is 1. `txrdy_n` is 1 exactly when `tx_count` is 1. A second push is dropped.
- R3: With `fifo_en`=1 and `dma_mode`=0, `rxrdy_n` is 0 whenever `rx_count`>=1. `txrdy_n` is 0 only when `tx_count`=0. Both follow the count in the same cycle.
- R4: With `fifo_en`=1 and `dma_mode`=1, `txrdy_n` is 0 while `tx_count`<16 and 1 when `tx_count`=16.
- R5: With `fifo_en`=1 and `dma_mode`=1, `rxrdy_n` falls one cycle after `rx_count` first reaches the threshold. The `rx_trig` encoding is 00=1, 01=4, 10=8, 11=14 bytes.
- R6: In block mode, `rx_timeout`=1 while `rx_count`>=1 drives `rxrdy_n` low one cycle later, below the threshold. A timeout with `rx_count`=0 has no effect.
- R7: In block mode a low `rxrdy_n` stays low while `rx_count` drops below the threshold. It returns to 1 one cycle after `rx_count` reaches 0.
- R8: Bytes leave each queue in push order. The read data is registered and valid in the cycle after the pop.
- R9: A push into a full queue (16 bytes, or 1 with `fifo_en`=0) is dropped and leaves the count unchanged. The overrun output of that side is 1 for one cycle, the cycle after. A push together with a pop on a full queue performs both.
- R10: A pop from an empty queue leaves the read data and the count unchanged.
- R11: A 1-to-0 change of `fifo_en` empties both queues by the next cycle and releases the block-mode receive latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = 16-byte queues, 0 = single holding registers |
| dma_mode | input | 1 | 1 = block-transfer ready behaviour (needs fifo_en) |
| rx_trig | input | 2 | Receive threshold select: 00=1, 01=4, 10=8, 11=14 |
| rx_timeout | input | 1 | Receive timeout indication |
| rx_push | input | 1 | Write a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Host read of the receive queue |
| rx_rdata | output | 8 | Registered receive read data |
| rx_count | output | 5 | Receive queue fill level |
| rx_overrun | output | 1 | One-cycle pulse after a dropped receive push |
| tx_push | input | 1 | Host write of a transmit byte |
| tx_wdata | input | 8 | Transmit byte |
| tx_pop | input | 1 | Shifter take of a transmit byte |
| tx_rdata | output | 8 | Registered transmit read data |
| tx_count | output | 5 | Transmit queue fill level |
| tx_overrun | output | 1 | One-cycle pulse after a dropped transmit push |
| rxrdy_n | output | 1 | Active-low receive service request |
| txrdy_n | output | 1 | Active-low transmit service request |

## Verification
Two cases are checked where two functions fall in the same cycle. The first is a push and a pop on a full transmit queue in one cycle. The bench drives both strobes together and checks two things: the count stays at 16 with no overrun, and the scoreboard still receives every byte in order. The second is a receive queue drained to zero while the block-mode latch is set. The bench checks that `rxrdy_n` is still low in the cycle the count reaches zero and high one cycle later, so the release takes exactly one register stage.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int TRIG_SEL_W = 2;

  function automatic int trig_bytes(input logic [TRIG_SEL_W-1:0] sel);
    case (sel)
      2'd0:    trig_bytes = 1;
      2'd1:    trig_bytes = 4;
      2'd2:    trig_bytes = 8;
      default: trig_bytes = 14;
    endcase
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wide,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count,
  output logic              overrun
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cap;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              ovr_q, ovr_d;
  logic              full, do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) ptr_inc = '0;
    else                        ptr_inc = p + PTR_W'(1);
  endfunction

  always_comb begin
    cap     = wide ? CNT_W'(DEPTH) : CNT_W'(1);
    full    = (cnt_q >= cap);
    do_pop  = pop && (cnt_q != '0) && !clear;
    do_push = push && !clear && (!full || do_pop);
    ovr_d   = push && !clear && full && !do_pop;
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    cnt_d   = cnt_q;
    rdata_d = rdata_q;
    if (clear) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (do_push) wptr_d = ptr_inc(wptr_q);
      if (do_pop) begin
        rptr_d  = ptr_inc(rptr_q);
        rdata_d = mem[rptr_q];
      end
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + CNT_W'(1);
        2'b01:   cnt_d = cnt_q - CNT_W'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      rdata_q <= '0;
      ovr_q   <= 1'b0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      cnt_q   <= cnt_d;
      rdata_q <= rdata_d;
      ovr_q   <= ovr_d;
    end
  end

  assign rdata   = rdata_q;
  assign count   = cnt_q;
  assign overrun = ovr_q;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R9
  AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clear && (cnt_q == cap)) |=> (cnt_q == $past(cnt_q)) && overrun); // R9
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !clear && (cnt_q == '0)) |=> $stable(rdata_q) && (cnt_q == '0)); // R10
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0) && !overrun); // R11
endmodule

// File: rtl/rx_ready.sv
module rx_ready
  import uart_fifo_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fifo_en,
  input  logic                  dma_mode,
  input  logic [TRIG_SEL_W-1:0] trig_sel,
  input  logic [CNT_W-1:0]      rx_count,
  input  logic                  rx_timeout,
  output logic                  rxrdy_n
);
  logic             blk_mode;
  logic             latch_q, latch_d;
  logic [CNT_W-1:0] trig_lvl;

  always_comb begin
    blk_mode = fifo_en && dma_mode;
    trig_lvl = CNT_W'(trig_bytes(trig_sel));
    latch_d  = blk_mode && (rx_count != '0) &&
               (latch_q || (rx_count >= trig_lvl) || rx_timeout);
    rxrdy_n  = blk_mode ? !latch_q : (rx_count == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= 1'b0;
    else        latch_q <= latch_d;
  end

  AST_TRIG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_mode && (rx_count >= trig_lvl) && (rx_count != '0)) |=> (!(fifo_en && dma_mode) || !rxrdy_n)); // R5
  AST_TIMEOUT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_mode && rx_timeout && (rx_count != '0)) |=> (!(fifo_en && dma_mode) || !rxrdy_n)); // R6
  AST_EMPTY_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_mode && (rx_count == '0)) |=> (!(fifo_en && dma_mode) || rxrdy_n)); // R7
  AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> !latch_q); // R11
endmodule

// File: rtl/tx_ready.sv
module tx_ready #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             fifo_en,
  input  logic             dma_mode,
  input  logic [CNT_W-1:0] tx_count,
  output logic             txrdy_n
);
  always_comb begin
    if (fifo_en && dma_mode) txrdy_n = (tx_count == CNT_W'(DEPTH));
    else                     txrdy_n = (tx_count != '0);
  end
endmodule

// File: rtl/uart_fifo_ready.sv
module uart_fifo_ready
  import uart_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fifo_en,
  input  logic                  dma_mode,
  input  logic [TRIG_SEL_W-1:0] rx_trig,
  input  logic                  rx_timeout,
  input  logic                  rx_push,
  input  logic [DATA_W-1:0]     rx_wdata,
  input  logic                  rx_pop,
  output logic [DATA_W-1:0]     rx_rdata,
  output logic [CNT_W-1:0]      rx_count,
  output logic                  rx_overrun,
  input  logic                  tx_push,
  input  logic [DATA_W-1:0]     tx_wdata,
  input  logic                  tx_pop,
  output logic [DATA_W-1:0]     tx_rdata,
  output logic [CNT_W-1:0]      tx_count,
  output logic                  tx_overrun,
  output logic                  rxrdy_n,
  output logic                  txrdy_n
);
  logic en_q, clear;

  always_comb clear = en_q && !fifo_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= fifo_en;
  end

  byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clear(clear), .wide(fifo_en),
    .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
    .rdata(rx_rdata), .count(rx_count), .overrun(rx_overrun)
  );

  byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clear(clear), .wide(fifo_en),
    .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
    .rdata(tx_rdata), .count(tx_count), .overrun(tx_overrun)
  );

  rx_ready #(.CNT_W(CNT_W)) u_rxrdy (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_mode(dma_mode),
    .trig_sel(rx_trig), .rx_count(rx_count), .rx_timeout(rx_timeout),
    .rxrdy_n(rxrdy_n)
  );

  tx_ready #(.DEPTH(DEPTH)) u_txrdy (
    .fifo_en(fifo_en), .dma_mode(dma_mode), .tx_count(tx_count),
    .txrdy_n(txrdy_n)
  );

  AST_TX_FILL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && dma_mode && tx_push && !tx_pop && (tx_count == CNT_W'(DEPTH - 1)))
      |=> (!(fifo_en && dma_mode) || txrdy_n)); // R4
  AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (rx_count == '0) && (tx_count == '0)); // R11
  AST_NARROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !en_q) |-> (rx_count <= CNT_W'(1)) && (tx_count <= CNT_W'(1))); // R2
endmodule

// File: tb/uart_fifo_ready_test.sv
module uart_fifo_ready_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fifo_en, dma_mode, rx_timeout;
  logic [1:0] rx_trig;
  logic       rx_push, rx_pop, tx_push, tx_pop;
  logic [7:0] rx_wdata, tx_wdata, rx_rdata, tx_rdata;
  logic [4:0] rx_count, tx_count;
  logic       rx_overrun, tx_overrun, rxrdy_n, txrdy_n;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  logic       rx_pend = 1'b0, tx_pend = 1'b0;
  logic [7:0] rx_exp, tx_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fifo_ready uut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_mode(dma_mode),
    .rx_trig(rx_trig), .rx_timeout(rx_timeout),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
    .rx_rdata(rx_rdata), .rx_count(rx_count), .rx_overrun(rx_overrun),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
    .tx_rdata(tx_rdata), .tx_count(tx_count), .tx_overrun(tx_overrun),
    .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int cap();
    return fifo_en ? DEPTH : 1;
  endfunction

  task automatic rx_put(input logic [7:0] b);
    rx_push = 1'b1; rx_wdata = b;
    if (rxq.size() < cap()) rxq.push_back(b);
    tick();
    rx_push = 1'b0;
  endtask

  task automatic tx_put(input logic [7:0] b);
    tx_push = 1'b1; tx_wdata = b;
    if (txq.size() < cap()) txq.push_back(b);
    tick();
    tx_push = 1'b0;
  endtask

  task automatic rx_take();
    rx_pop = 1'b1; tick(); rx_pop = 1'b0;
  endtask

  task automatic tx_take();
    tx_pop = 1'b1; tick(); tx_pop = 1'b0;
  endtask

  // monitor: pop expected byte when a pop lands on a non-empty queue
  always @(posedge clk) begin
    if (rst_n && rx_pop && rxq.size() > 0) begin
      rx_exp = rxq.pop_front(); rx_pend = 1'b1;
    end
    if (rst_n && tx_pop && txq.size() > 0) begin
      tx_exp = txq.pop_front(); tx_pend = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rx_pend) begin check("R8 rx order", rx_rdata, rx_exp); rx_pend = 1'b0; end
    if (tx_pend) begin check("R8 tx order", tx_rdata, tx_exp); tx_pend = 1'b0; end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fifo_en = 1'b0; dma_mode = 1'b0; rx_trig = 2'd0; rx_timeout = 1'b0;
    rx_push = 1'b0; rx_pop = 1'b0; tx_push = 1'b0; tx_pop = 1'b0;
    rx_wdata = '0; tx_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 rxrdy_n", rxrdy_n, 1);
    check("R1 txrdy_n", txrdy_n, 0);
    check("R1 rx_count", rx_count, 0);
    check("R1 tx_count", tx_count, 0);
    check("R1 overrun", rx_overrun | tx_overrun, 0);

    // R2 holding-register mode
    rx_put(8'hA5);
    check("R2 rx_count", rx_count, 1);
    check("R2 rxrdy_n held", rxrdy_n, 0);
    rx_put(8'h5A);
    check("R2 second push dropped", rx_count, 1);
    check("R9 rx_overrun pulse", rx_overrun, 1);
    tick();
    check("R9 rx_overrun one cycle", rx_overrun, 0);
    rx_take();
    check("R2 rxrdy_n empty", rxrdy_n, 1);
    tx_put(8'h3C);
    check("R2 txrdy_n held", txrdy_n, 1);
    tx_take();
    check("R2 txrdy_n empty", txrdy_n, 0);
    // R10 pop from empty
    rx_take();
    check("R10 rdata kept", rx_rdata, 8'hA5);
    check("R10 count kept", rx_count, 0);

    // R3 queue mode, block mode off
    fifo_en = 1'b1;
    tick();
    rx_put(8'h11);
    check("R3 rxrdy_n one byte", rxrdy_n, 0);
    rx_put(8'h22);
    rx_put(8'h33);
    tx_put(8'h44);
    check("R3 txrdy_n one byte", txrdy_n, 1);
    tx_put(8'h55);
    tx_take();
    check("R3 txrdy_n not empty", txrdy_n, 1);
    tx_take();
    check("R3 txrdy_n empty", txrdy_n, 0);
    repeat (3) rx_take();
    check("R3 rxrdy_n drained", rxrdy_n, 1);

    // R4 block mode transmit side
    dma_mode = 1'b1;
    tick();
    for (int i = 0; i < DEPTH - 1; i++) tx_put(8'(8'h80 + i));
    check("R4 txrdy_n at 15", txrdy_n, 0);
    tx_put(8'h8F);
    check("R4 tx_count full", tx_count, 16);
    check("R4 txrdy_n at 16", txrdy_n, 1);
    tx_put(8'hEE);
    check("R9 tx full push dropped", tx_count, 16);
    check("R9 tx_overrun", tx_overrun, 1);
    // push and pop in the same cycle on a full queue
    tx_push = 1'b1; tx_pop = 1'b1; tx_wdata = 8'h90; txq.push_back(8'h90);
    tick();
    tx_push = 1'b0; tx_pop = 1'b0;
    check("R9 push+pop full count", tx_count, 16);
    check("R9 push+pop no overrun", tx_overrun, 0);
    for (int i = 0; i < DEPTH; i++) tx_take();
    check("R4 txrdy_n drained", txrdy_n, 0);
    check("R8 tx drained count", tx_count, 0);

    // R5 threshold 4
    rx_trig = 2'd1;
    for (int i = 0; i < 3; i++) rx_put(8'(8'h20 + i));
    tick();
    check("R5 below threshold", rxrdy_n, 1);
    rx_put(8'h23);
    check("R5 not yet latched", rxrdy_n, 1);
    tick();
    check("R5 latched one cycle later", rxrdy_n, 0);
    // R7 hold below threshold, release after empty
    rx_take(); rx_take();
    check("R7 held below threshold", rxrdy_n, 0);
    rx_take(); rx_take();
    check("R7 still low at count 0", rxrdy_n, 0);
    tick();
    check("R7 released after empty", rxrdy_n, 1);

    // R6 timeout with threshold 14
    rx_trig = 2'd3;
    rx_put(8'h61); rx_put(8'h62);
    tick();
    check("R6 no request before timeout", rxrdy_n, 1);
    rx_timeout = 1'b1; tick(); rx_timeout = 1'b0;
    check("R6 timeout request", rxrdy_n, 0);
    rx_take(); rx_take(); tick();
    check("R6 drained", rxrdy_n, 1);
    rx_timeout = 1'b1; tick(); rx_timeout = 1'b0; tick();
    check("R6 timeout when empty ignored", rxrdy_n, 1);

    // R5 threshold 8
    rx_trig = 2'd2;
    for (int i = 0; i < 7; i++) rx_put(8'(8'h40 + i));
    tick();
    check("R5 seven of eight", rxrdy_n, 1);
    rx_put(8'h47); tick();
    check("R5 eight latched", rxrdy_n, 0);

    // R11 disable clears both sides
    tx_put(8'h71); tx_put(8'h72);
    fifo_en = 1'b0;
    tick();
    rxq.delete(); txq.delete();
    check("R11 rx_count cleared", rx_count, 0);
    check("R11 tx_count cleared", tx_count, 0);
    check("R11 rxrdy_n", rxrdy_n, 1);
    check("R11 txrdy_n", txrdy_n, 0);
    fifo_en = 1'b1;
    tick();
    check("R11 latch released", rxrdy_n, 1);
    // R5 threshold 1
    rx_trig = 2'd0;
    rx_put(8'h99); tick();
    check("R5 threshold one", rxrdy_n, 0);
    rx_take(); tick();
    check("R7 release threshold one", rxrdy_n, 1);

    tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule